// File: doc/BRIEF.md
# Serial Receive Queue with Trigger Flags

This block is the receive side of a serial controller. It holds a small byte queue filled from one of two sources: the line deserializer in normal operation, or the local transmit path when loopback is selected. The CPU drains it through a show-ahead data port: the oldest byte is always on `rd_data`, and a one-cycle `rd_en` removes it. The current byte count is always visible.

Three status flags track the queue against a trigger level that software picks. `rdf` means the queue has reached the level. `dr` means a few bytes are waiting below the level and the line has gone quiet. `orer` means a byte was lost because the queue was full. The flags drive a receive interrupt, a receive error interrupt and a one-cycle DMA request. A flush input empties the queue. Status writes follow write-zero-to-clear rules that cannot erase a condition that still holds.

Top module: `serial_rx_queue`

## Requirements
- R1: After reset the queue is empty (`level` = 0) and `dr`, `rdf`, `orer`, `rx_irq`, `err_irq` and `dma_req` are all low.
- R2: Bytes leave in arrival order. `rd_data` shows the oldest stored byte. A read (`rd_en` high for one cycle) of an empty queue shows 0x00 and changes no flag and no count.
- R3: `trig_sel` picks the trigger level: 2'b00 = 1, 2'b01 = 4, 2'b10 = 8, 2'b11 = 14 bytes. When an accepted byte brings the count to or above the level, `rdf` is set and `dma_req` is high for the next cycle. `rx_irq` is raised if `rx_int_en` is high.
- R4: When a read leaves the count below the level, `rdf` clears. When a read leaves the queue empty, `dr` also clears. `rx_irq` drops once both `dr` and `rdf` are clear.
- R5: A byte that arrives while 16 bytes are stored is dropped and `level` stays 16. `orer` is set, and `err_irq` is raised if `err_int_en` is high.
- R6: A write to the overrun flag (`ovr_wr`) with `ovr_wdata` = 0 clears `orer`. A write of 1 does nothing. The same clearing write drops `err_irq` only when `er_flag` is low.
- R7: On a `bit_tick`, `dr` is set if no byte arrived since the previous tick or during the tick before that, the queue is not empty, the count is below the level and `dr` was clear. Setting `dr` also raises `rx_irq` if it is enabled and pulses `dma_req`.
- R8: `flush` empties the queue and clears `dr`, `rdf` and `rx_irq` on the next edge.
- R9: On a status write (`st_wr`), `rdf` stays set while the count is at or above the level, and otherwise follows `st_rdf_wdata` (0 clears it). `dr` stays set only if it was set, `st_dr_wdata` is 1 and the queue is not empty. A status write never sets a clear flag.
- R10: With `rx_int_en` low, `rx_irq` is low on the next cycle. With both `rx_int_en` and `err_int_en` low, `err_irq` is low on the next cycle.
- R11: With `lb_en` high, the queue takes bytes from `lb_valid`/`lb_data` and ignores `line_valid`. With `lb_en` low, it takes bytes from the line and ignores the loopback inputs.
- R12: `level` always equals the number of stored bytes, from 0 to 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_valid | input | 1 | Byte strobe from the line deserializer |
| line_data | input | DW (8) | Byte from the line deserializer |
| lb_en | input | 1 | Loopback select |
| lb_valid | input | 1 | Byte strobe from the transmit path |
| lb_data | input | DW (8) | Byte from the transmit path |
| bit_tick | input | 1 | Serial timing tick for idle detection |
| rd_en | input | 1 | CPU read of the oldest byte |
| rd_data | output | DW (8) | Oldest byte, 0x00 when empty |
| level | output | CW (5) | Stored byte count |
| flush | input | 1 | Empty the queue |
| trig_sel | input | 2 | Trigger level select |
| rx_int_en | input | 1 | Receive interrupt enable |
| err_int_en | input | 1 | Receive error interrupt enable |
| er_flag | input | 1 | Receive error status from the line checker |
| st_wr | input | 1 | Status flag write strobe |
| st_dr_wdata | input | 1 | Value written to `dr` |
| st_rdf_wdata | input | 1 | Value written to `rdf` |
| ovr_wr | input | 1 | Overrun flag write strobe |
| ovr_wdata | input | 1 | Value written to `orer` |
| dr | output | 1 | Data ready below the trigger level |
| rdf | output | 1 | Trigger level reached |
| orer | output | 1 | Overrun occurred |
| rx_irq | output | 1 | Receive interrupt |
| err_irq | output | 1 | Receive error interrupt |
| dma_req | output | 1 | One-cycle DMA request |

## Verification
The bench builds the block with its default values: 8-bit data and a depth of 16. With these values a full queue and the 17th dropped byte need only a few dozen cycles, so the overrun path is tested twice. All four trigger encodings fit within that depth. The level of 14 sits two entries below full, so `rdf` rising before the overrun is observable. The level of 8 leaves room to hold a short queue below the trigger while the idle tick sequence runs.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;

  // Trigger selector to byte level.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Count after one cycle of push, pop or flush.
  function automatic int unsigned next_count(input int unsigned cur, input logic inc,
                                             input logic dec, input logic clr);
    if (clr) return 0;
    return cur + (inc ? 1 : 0) - (dec ? 1 : 0);
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import serial_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push_req,
  input  logic [DW-1:0] push_data,
  input  logic          pop_req,
  output logic          push_ok,
  output logic          pop_ok,
  output logic          overrun_evt,
  output logic [DW-1:0] head_data,
  output logic [CW-1:0] count,
  output logic [CW-1:0] count_next
);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, empty;

  assign full        = (count == CW'(DEPTH));
  assign empty       = (count == '0);
  assign push_ok     = push_req && !full && !flush;
  assign overrun_evt = push_req && full && !flush;
  assign pop_ok      = pop_req && !empty && !flush;
  assign head_data   = empty ? '0 : mem[rd_ptr];
  assign count_next  = CW'(next_count(32'(count), push_ok, pop_ok, flush));

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      count <= count_next;
      if (flush) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= step(wr_ptr);
        if (pop_ok)  rd_ptr <= step(rd_ptr);
      end
    end
  end

  // R12
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R5
  drop_keeps_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun_evt && !pop_ok) |=> count == $past(count));

  // R8
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> count == '0);

endmodule

// File: rtl/rxq_flags.sv
module rxq_flags #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [CW-1:0] trig,
  input  logic [CW-1:0] count_next,
  input  logic          push_req,
  input  logic          push_ok,
  input  logic          pop_ok,
  input  logic          overrun_evt,
  input  logic          bit_tick,
  input  logic          st_wr,
  input  logic          st_dr_wdata,
  input  logic          st_rdf_wdata,
  input  logic          ovr_wr,
  input  logic          ovr_wdata,
  output logic          dr,
  output logic          rdf,
  output logic          orer,
  output logic          dr_n,
  output logic          rdf_n,
  output logic          rdf_set_evt,
  output logic          dr_set_evt,
  output logic          orer_clr_evt
);

  logic arr_pend, arr_prev, arr_cur, at_level, idle_hit;

  assign arr_cur      = arr_pend || push_req;
  assign at_level     = (count_next >= trig);
  assign idle_hit     = bit_tick && !arr_cur && !arr_prev && !dr &&
                        (count_next != '0) && !at_level && !flush;
  assign orer_clr_evt = ovr_wr && !ovr_wdata;

  always_comb begin
    dr_n        = dr;
    rdf_n       = rdf;
    rdf_set_evt = 1'b0;
    dr_set_evt  = 1'b0;
    if (flush) begin
      dr_n  = 1'b0;
      rdf_n = 1'b0;
    end else begin
      if (st_wr) begin
        rdf_n = rdf && (st_rdf_wdata || at_level);
        dr_n  = dr && st_dr_wdata && (count_next != '0);
      end
      if (idle_hit) begin
        dr_n       = 1'b1;
        dr_set_evt = 1'b1;
      end
      if (pop_ok) begin
        if (!at_level)          rdf_n = 1'b0;
        if (count_next == '0)   dr_n  = 1'b0;
      end
      if (push_ok && at_level) begin
        rdf_n       = 1'b1;
        rdf_set_evt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dr       <= 1'b0;
      rdf      <= 1'b0;
      orer     <= 1'b0;
      arr_pend <= 1'b0;
      arr_prev <= 1'b0;
    end else begin
      dr  <= dr_n;
      rdf <= rdf_n;
      if (overrun_evt)       orer <= 1'b1;
      else if (orer_clr_evt) orer <= 1'b0;
      if (bit_tick) begin
        arr_prev <= arr_cur;
        arr_pend <= 1'b0;
      end else if (push_req) begin
        arr_pend <= 1'b1;
      end
    end
  end

  // R5
  overrun_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> orer);

  // R4
  read_drops_rdf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_ok && !push_ok && !at_level) |=> !rdf);

  // R9
  status_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_wr && !dr && !bit_tick) |=> !dr);

endmodule

// File: rtl/rxq_irq.sv
module rxq_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_int_en,
  input  logic err_int_en,
  input  logic er_flag,
  input  logic dr_n,
  input  logic rdf_n,
  input  logic rdf_set_evt,
  input  logic dr_set_evt,
  input  logic overrun_evt,
  input  logic orer_clr_evt,
  output logic rx_irq,
  output logic err_irq,
  output logic dma_req
);

  logic rx_raise, err_keep;

  assign rx_raise = rdf_set_evt || dr_set_evt;
  assign err_keep = err_irq && (rx_int_en || err_int_en) &&
                    !(orer_clr_evt && !er_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_irq  <= 1'b0;
      err_irq <= 1'b0;
      dma_req <= 1'b0;
    end else begin
      rx_irq  <= rx_int_en && (dr_n || rdf_n) && (rx_raise || rx_irq);
      err_irq <= (err_int_en && overrun_evt) || err_keep;
      dma_req <= rx_raise;
    end
  end

  // R10
  rx_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_int_en |=> !rx_irq);

  // R10
  err_en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_int_en && !err_int_en) |=> !err_irq);

  // R3
  dma_follows_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_raise |=> dma_req);

endmodule

// File: rtl/serial_rx_queue.sv
module serial_rx_queue
  import serial_rx_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          line_valid,
  input  logic [DW-1:0] line_data,
  input  logic          lb_en,
  input  logic          lb_valid,
  input  logic [DW-1:0] lb_data,
  input  logic          bit_tick,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [CW-1:0] level,
  input  logic          flush,
  input  logic [1:0]    trig_sel,
  input  logic          rx_int_en,
  input  logic          err_int_en,
  input  logic          er_flag,
  input  logic          st_wr,
  input  logic          st_dr_wdata,
  input  logic          st_rdf_wdata,
  input  logic          ovr_wr,
  input  logic          ovr_wdata,
  output logic          dr,
  output logic          rdf,
  output logic          orer,
  output logic          rx_irq,
  output logic          err_irq,
  output logic          dma_req
);

  logic          push_req, push_ok, pop_ok, overrun_evt;
  logic [DW-1:0] push_data;
  logic [CW-1:0] count_next, trig;
  logic          dr_n, rdf_n, rdf_set_evt, dr_set_evt, orer_clr_evt;

  assign push_req  = lb_en ? lb_valid : line_valid;
  assign push_data = lb_en ? lb_data  : line_data;
  assign trig      = CW'(trig_level(trig_sel));

  rxq_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .push_req(push_req), .push_data(push_data), .pop_req(rd_en),
    .push_ok(push_ok), .pop_ok(pop_ok), .overrun_evt(overrun_evt),
    .head_data(rd_data), .count(level), .count_next(count_next)
  );

  rxq_flags #(.CW(CW)) u_flags (
    .clk(clk), .rst_n(rst_n), .flush(flush), .trig(trig),
    .count_next(count_next), .push_req(push_req), .push_ok(push_ok),
    .pop_ok(pop_ok), .overrun_evt(overrun_evt), .bit_tick(bit_tick),
    .st_wr(st_wr), .st_dr_wdata(st_dr_wdata), .st_rdf_wdata(st_rdf_wdata),
    .ovr_wr(ovr_wr), .ovr_wdata(ovr_wdata),
    .dr(dr), .rdf(rdf), .orer(orer), .dr_n(dr_n), .rdf_n(rdf_n),
    .rdf_set_evt(rdf_set_evt), .dr_set_evt(dr_set_evt),
    .orer_clr_evt(orer_clr_evt)
  );

  rxq_irq u_irq (
    .clk(clk), .rst_n(rst_n), .rx_int_en(rx_int_en), .err_int_en(err_int_en),
    .er_flag(er_flag), .dr_n(dr_n), .rdf_n(rdf_n),
    .rdf_set_evt(rdf_set_evt), .dr_set_evt(dr_set_evt),
    .overrun_evt(overrun_evt), .orer_clr_evt(orer_clr_evt),
    .rx_irq(rx_irq), .err_irq(err_irq), .dma_req(dma_req)
  );

  // R7
  dr_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dr |-> level != '0);

  // R4
  irq_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> (dr || rdf));

  // R2
  empty_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0) |-> rd_data == '0);

endmodule

// File: tb/serial_rx_queue_bench.sv
module serial_rx_queue_bench;
  localparam int CLK_P = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       line_valid = 0, lb_en = 0, lb_valid = 0, bit_tick = 0, rd_en = 0;
  logic [7:0] line_data = 0, lb_data = 0, rd_data;
  logic [4:0] level;
  logic       flush = 0, rx_int_en = 0, err_int_en = 0, er_flag = 0;
  logic [1:0] trig_sel = 0;
  logic       st_wr = 0, st_dr_wdata = 0, st_rdf_wdata = 0, ovr_wr = 0, ovr_wdata = 0;
  logic       dr, rdf, orer, rx_irq, err_irq, dma_req;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  serial_rx_queue u_serial_rx_queue (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic push_line(input logic [7:0] b);
    @(negedge clk); line_valid = 1; line_data = b;
    @(negedge clk); line_valid = 0;
  endtask

  task automatic read_exp(input string req, input logic [7:0] b);
    @(negedge clk); chk(req, rd_data, b); rd_en = 1;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1;
    @(negedge clk); bit_tick = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1;
    @(negedge clk); flush = 0;
  endtask

  task automatic t_reset();
    chk("R1 level", level, 0);
    chk("R1 flags", {dr, rdf, orer}, 0);
    chk("R1 irqs", {rx_irq, err_irq, dma_req}, 0);
  endtask

  task automatic t_trigger();
    trig_sel = 2'b01; rx_int_en = 1;
    for (int i = 0; i < 3; i++) push_line(8'hA0 + 8'(i));
    chk("R3 below level", rdf, 0);
    chk("R12 count", level, 3);
    push_line(8'hA3);
    chk("R3 rdf at level 4", rdf, 1);
    chk("R3 dma pulse", dma_req, 1);
    chk("R3 rx_irq", rx_irq, 1);
    @(negedge clk);
    chk("R3 dma one cycle", dma_req, 0);
    read_exp("R2 oldest first", 8'hA0);
    chk("R4 rdf cleared", rdf, 0);
    chk("R4 irq dropped", rx_irq, 0);
    for (int i = 1; i < 4; i++) read_exp("R2 order", 8'hA0 + 8'(i));
    chk("R12 drained", level, 0);
    read_exp("R2 empty read", 8'h00);
    chk("R2 empty flags", {dr, rdf, level}, 0);
  endtask

  task automatic t_overrun();
    trig_sel = 2'b11; err_int_en = 1;
    for (int i = 0; i < 16; i++) begin
      push_line(8'h40 + 8'(i));
      if (i == 12) chk("R3 level 14 not yet", rdf, 0);
      if (i == 13) chk("R3 level 14 reached", rdf, 1);
    end
    chk("R5 no overrun yet", orer, 0);
    push_line(8'hEE);
    chk("R5 orer", orer, 1);
    chk("R5 err_irq", err_irq, 1);
    chk("R5 level held", level, 16);
    for (int i = 0; i < 16; i++) read_exp("R5 dropped byte absent", 8'h40 + 8'(i));
    chk("R5 empty after", level, 0);
    er_flag = 1;
    @(negedge clk); ovr_wr = 1; ovr_wdata = 0;
    @(negedge clk); ovr_wr = 0;
    chk("R6 orer cleared", orer, 0);
    chk("R6 err_irq held by er", err_irq, 1);
    er_flag = 0;
    @(negedge clk); ovr_wr = 1; ovr_wdata = 1;
    @(negedge clk); ovr_wr = 0;
    chk("R6 write one no effect", {orer, err_irq}, 1);
    @(negedge clk); ovr_wr = 1; ovr_wdata = 0;
    @(negedge clk); ovr_wr = 0;
    chk("R6 err_irq dropped", err_irq, 0);
    for (int i = 0; i < 17; i++) push_line(8'h10);
    chk("R5 second overrun", err_irq, 1);
    chk("R10 rx_irq before", rx_irq, 1);
    @(negedge clk); rx_int_en = 0; err_int_en = 0;
    @(negedge clk);
    chk("R10 irqs off", {rx_irq, err_irq}, 0);
    chk("R10 flags kept", {rdf, orer}, 2'b11);
    do_flush();
    chk("R8 flushed", {level, rdf}, 0);
    @(negedge clk); ovr_wr = 1; ovr_wdata = 0;
    @(negedge clk); ovr_wr = 0;
  endtask

  task automatic t_idle();
    trig_sel = 2'b10; rx_int_en = 1;
    push_line(8'h51); push_line(8'h52);
    tick();
    chk("R7 tick after arrival", dr, 0);
    tick();
    chk("R7 one quiet tick", dr, 0);
    tick();
    chk("R7 dr set", dr, 1);
    chk("R7 dma", dma_req, 1);
    chk("R7 rx_irq", rx_irq, 1);
    read_exp("R4 read keeps dr", 8'h51);
    chk("R4 dr kept", dr, 1);
    read_exp("R4 last byte", 8'h52);
    chk("R4 dr cleared", {dr, rx_irq}, 0);
  endtask

  task automatic t_status();
    push_line(8'h61); push_line(8'h62);
    tick(); tick(); tick();
    chk("R7 dr set again", dr, 1);
    @(negedge clk); st_wr = 1; st_dr_wdata = 1; st_rdf_wdata = 1;
    @(negedge clk); st_wr = 0;
    chk("R9 write one keeps dr", dr, 1);
    @(negedge clk); st_wr = 1; st_dr_wdata = 0;
    @(negedge clk); st_wr = 0;
    chk("R9 dr cleared", {dr, rx_irq}, 0);
    @(negedge clk); st_wr = 1; st_dr_wdata = 1;
    @(negedge clk); st_wr = 0;
    chk("R9 no set", dr, 0);
    trig_sel = 2'b00;
    push_line(8'h63);
    chk("R3 level 1", rdf, 1);
    @(negedge clk); st_wr = 1; st_rdf_wdata = 0; st_dr_wdata = 0;
    @(negedge clk); st_wr = 0;
    chk("R9 rdf held at level", rdf, 1);
    trig_sel = 2'b11;
    @(negedge clk); st_wr = 1; st_rdf_wdata = 0;
    @(negedge clk); st_wr = 0;
    chk("R9 rdf cleared below level", rdf, 0);
    trig_sel = 2'b00;
    push_line(8'h64);
    chk("R8 pre flush", {rdf, rx_irq, level}, {2'b11, 5'd4});
    do_flush();
    chk("R8 flush", {dr, rdf, rx_irq, level}, 0);
  endtask

  task automatic t_loopback();
    lb_en = 1;
    @(negedge clk); line_valid = 1; line_data = 8'h11; lb_valid = 1; lb_data = 8'h22;
    @(negedge clk); line_valid = 0; lb_valid = 0;
    chk("R11 one byte", level, 1);
    chk("R11 loopback data", rd_data, 8'h22);
    push_line(8'h33);
    chk("R11 line ignored", level, 1);
    lb_en = 0;
    @(negedge clk); lb_valid = 1; lb_data = 8'h44;
    @(negedge clk); lb_valid = 0;
    chk("R11 loopback ignored", level, 1);
    do_flush();
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_trigger();
    t_overrun();
    t_idle();
    t_status();
    t_loopback();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule